// File: doc/BRIEF.md
# Read-Port Chip-Select Controller

This block sits on the read side of a synchronous FIFO whose output bus can be tri-stated. It samples an active-low chip select on every rising read-clock edge and uses that registered value to decide whether the output word is driven. It gates the read strobe and the retransmit strobe that go to the FIFO's pointer logic. It also owns the output register. In first-word-fall-through mode it loads that register on its own whenever it is empty and the FIFO holds data.

The chip select affects only the drive of the bus and the strobes. The empty flag and the fall-through of the first word run as if the chip select were not there. An asynchronous active-low output enable gates the bus combinationally. While the FIFO is in master or partial reset, the output enable alone decides whether the bus is driven. A one-cycle protocol-error pulse is raised if a read is attempted on the same edge at which the chip select is first seen low.

Top module: `rdport_cs_ctrl`

## Requirements
- R1: With reset inactive and `oe_n` low, a rising edge that samples `cs_n` low makes `bus_en` 1 from that edge on.
- R2: With reset inactive, a rising edge that samples `cs_n` high makes `bus_en` 0 from that edge on.
- R3: `oe_n` high forces `bus_en` to 0 at once. While `reset_busy` is 1, `bus_en` equals the inverse of `oe_n` whatever `cs_n` is.
- R4: After `reset_busy` falls, `bus_en` stays 1 if `oe_n` is low until the first rising edge. From that edge on, the registered chip select decides.
- R5: In standard mode (`fwft_mode`=0), `empty_out` equals `mem_empty`. In fall-through mode, `empty_out` is 0 exactly when the output register holds an unread word. It falls one edge after the FIFO becomes non-empty, whatever `cs_n` is.
- R6: In fall-through mode, the first word written into an empty FIFO is loaded into the output register and popped (`mem_pop`=1) even while `cs_n` is high. It appears on `q_out` once a later edge samples `cs_n` low.
- R7: In standard mode, `mem_pop` is 1 and the output register loads `mem_head` only on an edge where `cs_n` and `ren_n` are both low, `mem_empty` is 0 and reset is inactive. In fall-through mode, such an edge pops the next word, or empties the register if the FIFO is empty.
- R8: `prot_err` is 1 for the cycle after an edge that samples `cs_n` low and `ren_n` low when the edge before it sampled `cs_n` high. A chip-select entry with `ren_n` high gives no pulse.
- R9: `retx_strobe` is 1 only while `retx_req` is 1, `cs_n` is low and `reset_busy` is 0.
- R10: `q_out` is all zeros whenever `bus_en` is 0, and equals the output register otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| reset_busy | input | 1 | FIFO master or partial reset is in progress |
| fwft_mode | input | 1 | 1 selects first-word fall-through, 0 selects standard mode |
| oe_n | input | 1 | Asynchronous active-low output enable |
| cs_n | input | 1 | Synchronous active-low read chip select |
| ren_n | input | 1 | Active-low read enable |
| retx_req | input | 1 | Retransmit request |
| mem_empty | input | 1 | FIFO storage holds no word |
| mem_head | input | DATA_W | Word at the FIFO read pointer |
| mem_pop | output | 1 | Gated read strobe, advances the read pointer |
| retx_strobe | output | 1 | Gated retransmit strobe |
| bus_en | output | 1 | Output bus drive enable |
| q_out | output | DATA_W | Output word, zero when not driven |
| empty_out | output | 1 | Empty flag seen by the reader |
| prot_err | output | 1 | Read attempted on the chip-select entry edge |

## Verification
A stuck or mis-timed chip-select register shows on `bus_en` at the first edge after `cs_n` changes. A reset-override bit left set keeps the bus driven one edge past reset release, or longer. A wrong valid bit in the output stage shows as `empty_out` that is one cycle late, or stuck. It can also show as a word that never falls through or is popped twice, and a wrong word then reaches `q_out` on the next read. Strobe gating faults show at once on `mem_pop` and `retx_strobe` within the same cycle as the offending inputs.

// File: rtl/rdcs_pkg.sv
`timescale 1ns/1ps
package rdcs_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rdcs_select.sv
`timescale 1ns/1ps
// Registered chip-select path, reset override and entry-protocol check.
module rdcs_select (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_busy,
  input  logic oe_n,
  input  logic cs_n,
  input  logic ren_n,
  output logic bus_en,
  output logic prot_err
);
  logic cs_drv_q, cs_drv_d;
  logic ovr_q, ovr_d;
  logic err_q, err_d;

  always_comb begin
    cs_drv_d = ~cs_n;
    ovr_d    = reset_busy;
    err_d    = ~reset_busy & ~cs_n & ~cs_drv_q & ~ren_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_drv_q <= 1'b0;
      ovr_q    <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      cs_drv_q <= cs_drv_d;
      ovr_q    <= ovr_d;
      err_q    <= err_d;
    end
  end

  assign bus_en   = ~oe_n & (reset_busy | ovr_q | cs_drv_q);
  assign prot_err = err_q;
endmodule

// File: rtl/rdcs_outreg.sv
`timescale 1ns/1ps
// Output register with standard and fall-through load policies.
module rdcs_outreg #(
  parameter int DATA_W = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reset_busy,
  input  rdcs_pkg::rd_mode_e   mode,
  input  logic                 cs_n,
  input  logic                 ren_n,
  input  logic                 mem_empty,
  input  logic [DATA_W-1:0]    mem_head,
  output logic                 pop,
  output logic [DATA_W-1:0]    data_q,
  output logic                 empty_out
);
  logic rd_req;
  logic load;
  logic valid_q, valid_d;
  logic [DATA_W-1:0] data_d;

  assign rd_req = ~cs_n & ~ren_n & ~reset_busy;

  always_comb begin
    load    = 1'b0;
    valid_d = valid_q;
    if (mode == rdcs_pkg::MODE_FWFT) begin
      load = ~reset_busy & ~mem_empty & (~valid_q | rd_req);
      if (reset_busy)   valid_d = 1'b0;
      else if (load)    valid_d = 1'b1;
      else if (rd_req)  valid_d = 1'b0;
    end else begin
      load    = rd_req & ~mem_empty;
      valid_d = 1'b0;
    end
    data_d = load ? mem_head : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) data_q <= data_d;
    end
  end

  assign pop       = load;
  assign empty_out = (mode == rdcs_pkg::MODE_FWFT) ? ~valid_q : mem_empty;
endmodule

// File: rtl/rdport_cs_ctrl.sv
`timescale 1ns/1ps
module rdport_cs_ctrl #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_busy,
  input  logic              fwft_mode,
  input  logic              oe_n,
  input  logic              cs_n,
  input  logic              ren_n,
  input  logic              retx_req,
  input  logic              mem_empty,
  input  logic [DATA_W-1:0] mem_head,
  output logic              mem_pop,
  output logic              retx_strobe,
  output logic              bus_en,
  output logic [DATA_W-1:0] q_out,
  output logic              empty_out,
  output logic              prot_err
);
  rdcs_pkg::rd_mode_e mode;
  logic [DATA_W-1:0]  data_q;

  assign mode = fwft_mode ? rdcs_pkg::MODE_FWFT : rdcs_pkg::MODE_STD;

  rdcs_select i_select (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_busy (reset_busy),
    .oe_n       (oe_n),
    .cs_n       (cs_n),
    .ren_n      (ren_n),
    .bus_en     (bus_en),
    .prot_err   (prot_err)
  );

  rdcs_outreg #(.DATA_W(DATA_W)) i_outreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_busy (reset_busy),
    .mode       (mode),
    .cs_n       (cs_n),
    .ren_n      (ren_n),
    .mem_empty  (mem_empty),
    .mem_head   (mem_head),
    .pop        (mem_pop),
    .data_q     (data_q),
    .empty_out  (empty_out)
  );

  assign retx_strobe = retx_req & ~cs_n & ~reset_busy;
  assign q_out       = bus_en ? data_q : '0;
endmodule

// File: rtl/rdcs_chk.sv
`timescale 1ns/1ps
module rdcs_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reset_busy,
  input logic              fwft_mode,
  input logic              oe_n,
  input logic              cs_n,
  input logic              ren_n,
  input logic              mem_empty,
  input logic              mem_pop,
  input logic              retx_strobe,
  input logic              bus_en,
  input logic [DATA_W-1:0] q_out,
  input logic              empty_out,
  input logic              prot_err
);
  // R1
  cs_low_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_busy && !cs_n && !oe_n) |=> (reset_busy || oe_n || bus_en));
  // R2
  cs_high_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_busy && cs_n) |=> (reset_busy || !bus_en));
  // R3
  oe_forces_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !bus_en);
  // R3
  reset_oe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_busy |-> (bus_en == !oe_n));
  // R5
  std_empty_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fwft_mode |-> (empty_out == mem_empty));
  // R6
  fwft_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft_mode && !reset_busy && !mem_empty && empty_out) |-> mem_pop);
  // R7
  std_read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft_mode && mem_pop) |-> (!cs_n && !ren_n && !mem_empty));
  // R8
  prot_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_busy && !cs_n && !ren_n && $past(cs_n)) |=> prot_err);
  // R9
  retx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retx_strobe |-> (!cs_n && !reset_busy));
  // R10
  float_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> (q_out == '0));
endmodule

bind rdport_cs_ctrl rdcs_chk #(.DATA_W(DATA_W)) i_rdcs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reset_busy  (reset_busy),
  .fwft_mode   (fwft_mode),
  .oe_n        (oe_n),
  .cs_n        (cs_n),
  .ren_n       (ren_n),
  .mem_empty   (mem_empty),
  .mem_pop     (mem_pop),
  .retx_strobe (retx_strobe),
  .bus_en      (bus_en),
  .q_out       (q_out),
  .empty_out   (empty_out),
  .prot_err    (prot_err)
);

// File: tb/test_rdport_cs_ctrl.sv
`timescale 1ns/1ps
module test_rdport_cs_ctrl;
  localparam int DW = 36;

  logic clk, rst_n, reset_busy, fwft_mode, oe_n, cs_n, ren_n, retx_req;
  logic mem_empty, mem_pop, retx_strobe, bus_en, empty_out, prot_err;
  logic [DW-1:0] mem_head, q_out;

  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] mem [16];
  logic [4:0]    wp, rp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [DW-1:0] WA = 36'h1_0000_00A1;
  localparam logic [DW-1:0] WB = 36'h2_0000_00B2;
  localparam logic [DW-1:0] WC = 36'h3_0000_00C3;
  localparam logic [DW-1:0] WD = 36'h4_0000_00D4;
  localparam logic [DW-1:0] WE = 36'h5_0000_00E5;
  localparam logic [DW-1:0] WF = 36'h6_0000_00F6;

  rdport_cs_ctrl #(.DATA_W(DW)) i_rdport_cs_ctrl (
    .clk(clk), .rst_n(rst_n), .reset_busy(reset_busy), .fwft_mode(fwft_mode),
    .oe_n(oe_n), .cs_n(cs_n), .ren_n(ren_n), .retx_req(retx_req),
    .mem_empty(mem_empty), .mem_head(mem_head), .mem_pop(mem_pop),
    .retx_strobe(retx_strobe), .bus_en(bus_en), .q_out(q_out),
    .empty_out(empty_out), .prot_err(prot_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // simple word queue standing in for the FIFO storage
  always_ff @(posedge clk) begin
    if (reset_busy) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en) begin
        mem[wp[3:0]] <= wr_data;
        wp <= wp + 5'd1;
      end
      if (retx_strobe)  rp <= '0;
      else if (mem_pop) rp <= rp + 5'd1;
    end
  end
  assign mem_empty = (rp == wp);
  assign mem_head  = mem[rp[3:0]];

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_word(input logic [DW-1:0] w);
    wr_en = 1'b1; wr_data = w;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    #1 chk("R3 reset oe high floats", bus_en, 0);
    oe_n = 1'b0; #1;
    chk("R3 reset oe low drives", bus_en, 1);
    cs_n = 1'b1; tick();
    chk("R3 cs ignored in reset", bus_en, 1);
    reset_busy = 1'b0; #1;
    chk("R4 driven until first edge", bus_en, 1);
    tick();
    chk("R4 cs takes over after edge", bus_en, 0);
  endtask

  task automatic t_cs();
    cs_n = 1'b0; tick();
    chk("R1 cs low drives", bus_en, 1);
    chk("R8 entry with ren high no error", prot_err, 0);
    oe_n = 1'b1; #1;
    chk("R3 oe high floats at once", bus_en, 0);
    oe_n = 1'b0; cs_n = 1'b1; tick();
    chk("R2 cs high floats", bus_en, 0);
    chk("R10 floating bus zero", q_out, 0);
  endtask

  task automatic t_std_read();
    write_word(WA); write_word(WB); write_word(WC);
    chk("R5 empty passes through with cs high", empty_out, 0);
    cs_n = 1'b0; ren_n = 1'b1; tick();
    ren_n = 1'b0; #1;
    chk("R7 pop when cs and ren low", mem_pop, 1);
    tick();
    chk("R7 first word read", q_out, WA);
    tick();
    chk("R7 second word read", q_out, WB);
    cs_n = 1'b1; #1;
    chk("R7 no pop with cs high", mem_pop, 0);
    tick();
    chk("R2 bus floats after cs high", bus_en, 0);
  endtask

  task automatic t_prot();
    cs_n = 1'b0; ren_n = 1'b0; tick();
    chk("R8 read on entry edge flags error", prot_err, 1);
    chk("R7 read on entry edge", q_out, WC);
    ren_n = 1'b1; tick();
    chk("R8 error is one cycle", prot_err, 0);
    chk("R7 word held with ren high", q_out, WC);
  endtask

  task automatic t_retx();
    cs_n = 1'b1; retx_req = 1'b1; #1;
    chk("R9 retransmit blocked with cs high", retx_strobe, 0);
    cs_n = 1'b0; #1;
    chk("R9 retransmit passes with cs low", retx_strobe, 1);
    tick();
    retx_req = 1'b0; ren_n = 1'b0; tick();
    chk("R9 reread from start", q_out, WA);
    ren_n = 1'b1; cs_n = 1'b1; tick();
  endtask

  task automatic t_fwft();
    reset_busy = 1'b1; fwft_mode = 1'b1; tick(); tick();
    reset_busy = 1'b0; tick();
    chk("R5 fall-through empty after reset", empty_out, 1);
    write_word(WD);
    chk("R6 pop with cs high", mem_pop, 1);
    tick();
    chk("R5 empty falls with cs high", empty_out, 0);
    chk("R6 loaded word not driven", bus_en, 0);
    chk("R10 undriven word zero", q_out, 0);
    write_word(WE); write_word(WF);
    cs_n = 1'b0; tick();
    chk("R6 first word appears on cs low", q_out, WD);
    ren_n = 1'b0; tick();
    chk("R7 fall-through next word", q_out, WE);
    tick();
    chk("R7 fall-through third word", q_out, WF);
    tick();
    chk("R5 empty after last word read", empty_out, 1);
    ren_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; reset_busy = 1'b1; fwft_mode = 1'b0; oe_n = 1'b1;
    cs_n = 1'b1; ren_n = 1'b1; retx_req = 1'b0; wr_en = 1'b0; wr_data = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_cs();
    t_std_read();
    t_prot();
    t_retx();
    t_fwft();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule